// File: doc/BRIEF.md
# Single-Bit Boolean Processor

This block executes single-bit instructions against a carry flag that serves as a one-bit accumulator. Each operation selects one bit by an 8-bit bit address. Addresses with the top bit clear fold onto a 16-byte window of scratch RAM. Addresses with the top bit set fold onto sixteen register bytes whose byte addresses are multiples of eight. The block holds its own model of all 32 bytes. The carry itself lives in the status register byte, which is one of those sixteen.

A controller presents an opcode and a bit address with a one-cycle strobe. One clock later the block shows four results: the carry, a branch-taken decision and the updated byte that holds the addressed bit, with a done pulse marking them. Strobes may arrive on consecutive cycles, and each one sees the state left by the one before it. Branch target arithmetic and instruction fetch stay in the controller.

Top module: `bool_bit_unit`

## Requirements
- R1: After reset, carry, taken, done and rdata are 0, and every modelled byte reads as zero apart from the parity bit, which follows the accumulator.
- R2: A bit address below 80h selects bit addr[2:0] of RAM byte 20h + addr[6:3]. rdata returns that byte after the operation.
- R3: A bit address of 80h or above selects bit addr[2:0] of the register byte at address (addr AND F8h). rdata returns that byte after the operation.
- R4: The carry is bit 7 of the status byte D0h. Bit address D7h reads and writes the carry.
- R5: Opcode 0 gives C = C AND bit, 1 gives C = C AND NOT bit, 2 gives C = C OR bit, 3 gives C = C OR NOT bit, and 4 gives C = bit.
- R6: Opcode 5 writes C into the bit. Opcodes 9, 10 and 11 clear, set and invert the bit. The other seven bits of the byte keep their values.
- R7: Opcodes 6, 7 and 8 clear, set and invert the carry.
- R8: Opcodes 12 to 15 set taken when, in order, C is 1, C is 0, the bit is 1, or the bit is 0. Opcodes 0 to 11 leave taken at 0.
- R9: Opcode 16 sets taken when the bit is 1 and clears that bit in the same step. A bit that is 0 is left at 0 and taken is 0.
- R10: Opcode 17 (exclusive-OR of the carry) and opcodes 18 to 31 change no state. Taken is 0 and rdata returns the unchanged byte.
- R11: Bit 0 of the status byte always reads as the XOR of the bits of the accumulator byte E0h. Writes to that bit have no effect.
- R12: Results appear on the first clock edge after the strobe, and done pulses for that one cycle. Carry and rdata hold while no strobe is given. Back-to-back strobes each act on the state the previous one produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | Starts an operation this cycle |
| op | input | 5 | Operation code |
| bit_addr | input | 8 | Address of the operand bit |
| carry | output | 1 | Carry flag (status bit 7) |
| taken | output | 1 | Branch decision of the last operation |
| done | output | 1 | One-cycle pulse one clock after a strobe |
| rdata | output | 8 | Byte holding the addressed bit, after the last operation |

## Verification
Every result of an operation (carry, taken, rdata and done) is registered, so each one is due exactly one clock edge after the strobe that produced it. The bench drives inputs on the falling edge and samples on the next falling edge. That sample sits half a period after the edge that updates the registers. In bursts, the bench drives the next operation in the same falling-edge step, so consecutive strobes are checked one cycle apart. Idle cycles check that done returns to 0 and that carry and rdata hold.

// File: rtl/bool_bit_unit.sv
module bool_bit_unit #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic [4:0]    op,
  input  logic [AW-1:0] bit_addr,
  output logic          carry,
  output logic          taken,
  output logic          done,
  output logic [7:0]    rdata
);
  localparam int NB = 2 * (1 << (AW - 4));
  localparam int IW = $clog2(NB);
  localparam logic [IW-1:0] PSW_IDX = IW'(26);
  localparam logic [IW-1:0] ACC_IDX = IW'(28);

  localparam logic [4:0] OP_ANL = 5'd0, OP_ANLN = 5'd1, OP_ORL = 5'd2, OP_ORLN = 5'd3,
                         OP_MOVCB = 5'd4, OP_MOVBC = 5'd5, OP_CLRC = 5'd6, OP_SETC = 5'd7,
                         OP_CPLC = 5'd8, OP_CLRB = 5'd9, OP_SETB = 5'd10, OP_CPLB = 5'd11,
                         OP_JC = 5'd12, OP_JNC = 5'd13, OP_JB = 5'd14, OP_JNB = 5'd15,
                         OP_JBC = 5'd16, OP_XRL = 5'd17;

  logic [7:0] mem [NB];

  wire [IW-1:0] idx = {bit_addr[AW-1], bit_addr[AW-2:3]};
  wire [2:0]    pos = bit_addr[2:0];
  wire          par = ^mem[ACC_IDX];

  logic [7:0] cur, post;
  logic       b, c, nc, nb, wr_c, wr_b, tk;

  assign c     = mem[PSW_IDX][7];
  assign carry = c;
  assign cur   = (idx == PSW_IDX) ? {mem[idx][7:1], par} : mem[idx];
  assign b     = cur[pos];

  always_comb begin
    wr_c = 1'b0; nc = c; wr_b = 1'b0; nb = b; tk = 1'b0;
    case (op)
      OP_ANL:   begin wr_c = 1'b1; nc = c & b;  end
      OP_ANLN:  begin wr_c = 1'b1; nc = c & ~b; end
      OP_ORL:   begin wr_c = 1'b1; nc = c | b;  end
      OP_ORLN:  begin wr_c = 1'b1; nc = c | ~b; end
      OP_MOVCB: begin wr_c = 1'b1; nc = b;      end
      OP_MOVBC: begin wr_b = 1'b1; nb = c;      end
      OP_CLRC:  begin wr_c = 1'b1; nc = 1'b0;   end
      OP_SETC:  begin wr_c = 1'b1; nc = 1'b1;   end
      OP_CPLC:  begin wr_c = 1'b1; nc = ~c;     end
      OP_CLRB:  begin wr_b = 1'b1; nb = 1'b0;   end
      OP_SETB:  begin wr_b = 1'b1; nb = 1'b1;   end
      OP_CPLB:  begin wr_b = 1'b1; nb = ~b;     end
      OP_JC:    tk = c;
      OP_JNC:   tk = ~c;
      OP_JB:    tk = b;
      OP_JNB:   tk = ~b;
      OP_JBC:   begin tk = b; wr_b = 1'b1; nb = 1'b0; end
      default:  ;
    endcase
  end

  always_comb begin
    post = cur;
    if (wr_b) post[pos] = nb;
    if (wr_c && idx == PSW_IDX) post[7] = nc;
    if (idx == PSW_IDX) post[0] = par;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) mem[i] <= '0;
      taken <= 1'b0;
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= strobe;
      if (strobe) begin
        if (wr_c) mem[PSW_IDX][7] <= nc;
        if (wr_b) mem[idx][pos] <= nb;
        taken <= tk;
        rdata <= post;
      end
    end
  end

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) strobe |=> done);
  a_r12_done_idle:  assert property (@(posedge clk) disable iff (!rst_n) !strobe |=> !done);
  a_r12_hold:       assert property (@(posedge clk) disable iff (!rst_n)
                      !strobe |=> $stable(carry) && $stable(rdata));
  a_r7_set_carry:   assert property (@(posedge clk) disable iff (!rst_n)
                      strobe && op == OP_SETC |=> carry);
  a_r7_clr_carry:   assert property (@(posedge clk) disable iff (!rst_n)
                      strobe && op == OP_CLRC |=> !carry);
  a_r8_jc:          assert property (@(posedge clk) disable iff (!rst_n)
                      strobe && op == OP_JC |=> taken == $past(carry));
  a_r8_no_branch:   assert property (@(posedge clk) disable iff (!rst_n)
                      strobe && op < OP_JC |=> !taken);
  a_r10_xrl_inert:  assert property (@(posedge clk) disable iff (!rst_n)
                      strobe && op == OP_XRL |=> carry == $past(carry) && !taken);
endmodule

// File: tb/bool_bit_unit_tb.sv
`timescale 1ns/1ps
module bool_bit_unit_tb;
  logic clk = 1'b0, rst_n = 1'b0, strobe = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] bit_addr = '0;
  logic carry, taken, done;
  logic [7:0] rdata;
  int n_chk = 0, n_bad = 0;
  logic [7:0] mb [32];
  logic exp_c, exp_t;
  logic [7:0] exp_r;

  always #2 clk = ~clk;

  bool_bit_unit u_dut (.clk(clk), .rst_n(rst_n), .strobe(strobe), .op(op), .bit_addr(bit_addr),
                       .carry(carry), .taken(taken), .done(done), .rdata(rdata));

  function automatic logic [7:0] vb(input int i);
    return (i == 26) ? {mb[26][7:1], ^mb[28]} : mb[i];
  endfunction

  function automatic string optag(input logic [4:0] o);
    if (o <= 4) return "R5";
    if (o == 5 || (o >= 9 && o <= 11)) return "R6";
    if (o >= 6 && o <= 8) return "R7";
    if (o >= 12 && o <= 15) return "R8";
    if (o == 16) return "R9";
    return "R10";
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic do_op(input logic [4:0] o, input logic [7:0] a, input string tag);
    int i; int p; logic b; logic c; string t; string mt;
    i = {a[7], a[6:3]}; p = a[2:0];
    b = vb(i)[p]; c = mb[26][7];
    exp_t = 1'b0;
    case (o)
      5'd0: mb[26][7] = c & b;
      5'd1: mb[26][7] = c & ~b;
      5'd2: mb[26][7] = c | b;
      5'd3: mb[26][7] = c | ~b;
      5'd4: mb[26][7] = b;
      5'd5: mb[i][p] = c;
      5'd6: mb[26][7] = 1'b0;
      5'd7: mb[26][7] = 1'b1;
      5'd8: mb[26][7] = ~c;
      5'd9: mb[i][p] = 1'b0;
      5'd10: mb[i][p] = 1'b1;
      5'd11: mb[i][p] = ~b;
      5'd12: exp_t = c;
      5'd13: exp_t = ~c;
      5'd14: exp_t = b;
      5'd15: exp_t = ~b;
      5'd16: begin exp_t = b; mb[i][p] = 1'b0; end
      default: ;
    endcase
    exp_c = mb[26][7];
    exp_r = vb(i);
    strobe = 1'b1; op = o; bit_addr = a;
    @(negedge clk);
    t  = (tag != "") ? tag : optag(o);
    mt = (tag != "") ? tag : (a[7] ? "R3" : "R2");
    chk(t, "carry", {7'd0, carry}, {7'd0, exp_c});
    chk(t, "taken", {7'd0, taken}, {7'd0, exp_t});
    chk(mt, "rdata", rdata, exp_r);
    chk("R12", "done", {7'd0, done}, 8'd1);
  endtask

  task automatic idle();
    strobe = 1'b0;
    @(negedge clk);
    chk("R12", "done idle", {7'd0, done}, 8'd0);
    chk("R12", "carry hold", {7'd0, carry}, {7'd0, exp_c});
    chk("R12", "rdata hold", rdata, exp_r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < 32; i++) mb[i] = '0;
    exp_c = 1'b0; exp_r = '0;
    repeat (3) @(negedge clk);
    chk("R1", "carry rst", {7'd0, carry}, 8'd0);
    chk("R1", "taken rst", {7'd0, taken}, 8'd0);
    chk("R1", "done rst", {7'd0, done}, 8'd0);
    chk("R1", "rdata rst", rdata, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    do_op(5'd4, 8'h45, "R1");
    do_op(5'd14, 8'hB3, "R1");
    idle();
    do_op(5'd10, 8'h00, "R2");
    do_op(5'd10, 8'h7F, "R2");
    do_op(5'd10, 8'h83, "R3");
    do_op(5'd10, 8'hF9, "R3");
    do_op(5'd10, 8'hD7, "R4");
    do_op(5'd9, 8'hD7, "R4");
    do_op(5'd7, 8'hD3, "R4");
    do_op(5'd5, 8'h12, "R6");
    do_op(5'd11, 8'h15, "R6");
    do_op(5'd10, 8'hE0, "R11");
    do_op(5'd4, 8'hD0, "R11");
    do_op(5'd10, 8'hD0, "R11");
    do_op(5'd14, 8'hD0, "R11");
    do_op(5'd10, 8'hE5, "R11");
    do_op(5'd4, 8'hD0, "R11");
    do_op(5'd10, 8'h30, "R9");
    do_op(5'd16, 8'h30, "R9");
    do_op(5'd16, 8'h30, "R9");
    do_op(5'd17, 8'h31, "R10");
    do_op(5'd25, 8'hD7, "R10");
    do_op(5'd1, 8'h30, "R5");
    do_op(5'd3, 8'h30, "R5");
    idle();
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] a;
      case ($urandom_range(0, 3))
        0: a = {5'h1A, 3'($urandom_range(0, 7))};
        1: a = {5'h1C, 3'($urandom_range(0, 7))};
        default: a = 8'($urandom);
      endcase
      do_op(5'($urandom_range(0, 21)), a, "");
      if ($urandom_range(0, 4) == 0) idle();
    end
    idle();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule